// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Control Unit

This block steers operand bypassing and pipeline freezing for a five-stage in-order integer core (fetch, decode, execute, memory, writeback). Each cycle it compares the source register indices of the instruction in execute against the destinations held in the execute/memory and memory/writeback pipeline registers. For each ALU operand it picks a bypass select. The two operands are resolved separately, so they can take values from two different stages in the same cycle.

It also detects a load in execute whose destination is read by the instruction in decode. In that case it freezes the program counter and the fetch/decode register for one cycle and turns the execute-stage input into a bubble. When a branch resolves as taken in execute, it flushes the fetch/decode register, and this redirect outranks a load-use freeze raised in the same cycle. The bypass selects and the redirect outputs are combinational. The only state is a one-bit record of a freeze issued in the previous cycle, which bounds each freeze to one cycle.

Top module: `hzd_fwd_ctrl`

## Requirements
- R1: When the execute/memory register writes a nonzero destination equal to an operand's execute-stage source, that operand's select is 2'b10.
- R2: When only the memory/writeback register writes a nonzero destination equal to the source, the select is 2'b01. With no match the select is 2'b00, which means register file.
- R3: When both later stages write the same matching destination, the select is 2'b10: the newer result wins.
- R4: Operand A (select fwd_sel_a, source ex_rs1) and operand B (select fwd_sel_b, source ex_rs2) are resolved independently. Each can bypass from a different stage in the same cycle.
- R5: No bypass is selected from a stage whose register-write enable is low or whose destination is register 0.
- R6: A load in execute with write enable high, a nonzero destination, and that destination equal to id_rs1 or id_rs2 gives ifid_hold=1, ex_bubble=1 and pc_we=0 in that cycle. In the next cycle all three return to idle (hold 0, bubble 0, pc_we 1), even if the inputs still show the hazard.
- R7: No freeze occurs when the instruction in execute is not a load, when its destination is register 0, when its write enable is low, or when neither decode source matches it.
- R8: ifid_flush equals ex_br_taken in the same cycle. A not-taken branch leaves flush, hold and bubble at 0 and pc_we at 1.
- R9: When a taken branch and a load-use hazard occur in the same cycle, ifid_flush=1, ifid_hold=0, ex_bubble=0 and pc_we=1.
- R10: After reset, with all pipeline inputs idle, both selects are 2'b00, pc_we=1, and hold, bubble and flush are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_rs1 | input | REG_IDX_W | First source index of the decode-stage instruction |
| id_rs2 | input | REG_IDX_W | Second source index of the decode-stage instruction |
| ex_rs1 | input | REG_IDX_W | Operand A source index in execute |
| ex_rs2 | input | REG_IDX_W | Operand B source index in execute |
| ex_rd | input | REG_IDX_W | Destination index of the instruction in execute |
| ex_reg_we | input | 1 | Register-write enable of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_br_taken | input | 1 | Branch in execute resolved as taken |
| mem_rd | input | REG_IDX_W | Destination index in the execute/memory register |
| mem_reg_we | input | 1 | Write enable in the execute/memory register |
| wb_rd | input | REG_IDX_W | Destination index in the memory/writeback register |
| wb_reg_we | input | 1 | Write enable in the memory/writeback register |
| fwd_sel_a | output | 2 | Operand A bypass select (00 register file, 01 writeback, 10 memory) |
| fwd_sel_b | output | 2 | Operand B bypass select, same encoding |
| pc_we | output | 1 | Program counter write enable |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| ifid_flush | output | 1 | Clear the fetch/decode register |
| ex_bubble | output | 1 | Load a NOP into the execute stage |

## Verification
The bypass selects and the flush are combinational, so each is due in the same cycle as its stimulus. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. The freeze outputs also respond in the stimulus cycle. Their release is due one rising edge later, once the freeze-history bit has been loaded, so the one-cycle check holds the hazard inputs across exactly one rising edge and samples again after it. The flush-priority case first checks the combined cycle. It then drops the branch and checks that the freeze appears at once, which shows that the overridden freeze left no history behind.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_WB  = 2'b01,
      FWD_EXM = 2'b10
   } fwd_sel_e;

   localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/hfc_bypass_sel.sv
module hfc_bypass_sel #(
   parameter int unsigned IDX_W      = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [IDX_W-1:0]         src,
   input  logic [IDX_W-1:0]         mem_rd,
   input  logic                     mem_we,
   input  logic [IDX_W-1:0]         wb_rd,
   input  logic                     wb_we,
   output logic [hfc_pkg::SEL_W-1:0] sel
);
   import hfc_pkg::*;

   logic mem_hit;
   logic wb_hit;

   generate
      if (ZERO_GUARD) begin : g_guard
         always_comb begin
            mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
            wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
         end
      end else begin : g_noguard
         always_comb begin
            mem_hit = mem_we && (mem_rd == src);
            wb_hit  = wb_we  && (wb_rd  == src);
         end
      end
   endgenerate

   always_comb begin
      if (mem_hit)     sel = FWD_EXM;
      else if (wb_hit) sel = FWD_WB;
      else             sel = FWD_RF;
   end
endmodule

// File: rtl/hfc_load_use.sv
module hfc_load_use #(
   parameter int unsigned IDX_W      = 5,
   parameter int unsigned NUM_SRC    = 2,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC*IDX_W-1:0]   id_srcs,
   input  logic [IDX_W-1:0]           ex_rd,
   input  logic                       ex_we,
   input  logic                       ex_is_load,
   input  logic                       kill,
   output logic                       stall
);
   logic [NUM_SRC-1:0] src_hit;
   logic               rd_ok;
   logic               stall_q;

   generate
      if (ZERO_GUARD) begin : g_rd_guard
         assign rd_ok = ex_we && ex_is_load && (ex_rd != '0);
      end else begin : g_rd_plain
         assign rd_ok = ex_we && ex_is_load;
      end
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign src_hit[i] = (id_srcs[i*IDX_W +: IDX_W] == ex_rd);
      end
   endgenerate

   assign stall = rd_ok && (|src_hit) && !stall_q && !kill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stall_q <= 1'b0;
      else        stall_q <= stall;
   end
endmodule

// File: rtl/hfc_redirect_arb.sv
module hfc_redirect_arb (
   input  logic stall,
   input  logic br_taken,
   output logic pc_we,
   output logic ifid_hold,
   output logic ifid_flush,
   output logic ex_bubble
);
   logic freeze;

   always_comb begin
      freeze     = stall && !br_taken;
      ifid_flush = br_taken;
      ifid_hold  = freeze;
      ex_bubble  = freeze;
      pc_we      = !freeze;
   end
endmodule

// File: rtl/hzd_fwd_ctrl.sv
module hzd_fwd_ctrl #(
   parameter int unsigned REG_IDX_W  = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [REG_IDX_W-1:0] id_rs1,
   input  logic [REG_IDX_W-1:0] id_rs2,
   input  logic [REG_IDX_W-1:0] ex_rs1,
   input  logic [REG_IDX_W-1:0] ex_rs2,
   input  logic [REG_IDX_W-1:0] ex_rd,
   input  logic                 ex_reg_we,
   input  logic                 ex_is_load,
   input  logic                 ex_br_taken,
   input  logic [REG_IDX_W-1:0] mem_rd,
   input  logic                 mem_reg_we,
   input  logic [REG_IDX_W-1:0] wb_rd,
   input  logic                 wb_reg_we,
   output logic [1:0]           fwd_sel_a,
   output logic [1:0]           fwd_sel_b,
   output logic                 pc_we,
   output logic                 ifid_hold,
   output logic                 ifid_flush,
   output logic                 ex_bubble
);
   localparam int unsigned NUM_SRC = 2;
   localparam int unsigned SRC_BUS = NUM_SRC * REG_IDX_W;

   generate
      if (REG_IDX_W < 1 || REG_IDX_W > 8) begin : g_bad_width
         $error("hzd_fwd_ctrl: REG_IDX_W must lie in 1..8");
      end
   endgenerate

   logic [SRC_BUS-1:0] ex_srcs;
   logic [SRC_BUS-1:0] id_srcs;
   logic [NUM_SRC*hfc_pkg::SEL_W-1:0] sels;
   logic stall;

   assign ex_srcs = {ex_rs2, ex_rs1};
   assign id_srcs = {id_rs2, id_rs1};

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
         hfc_bypass_sel #(
            .IDX_W      (REG_IDX_W),
            .ZERO_GUARD (ZERO_GUARD)
         ) i_sel (
            .src    (ex_srcs[k*REG_IDX_W +: REG_IDX_W]),
            .mem_rd (mem_rd),
            .mem_we (mem_reg_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_reg_we),
            .sel    (sels[k*hfc_pkg::SEL_W +: hfc_pkg::SEL_W])
         );
      end
   endgenerate

   assign fwd_sel_a = sels[1:0];
   assign fwd_sel_b = sels[3:2];

   hfc_load_use #(
      .IDX_W      (REG_IDX_W),
      .NUM_SRC    (NUM_SRC),
      .ZERO_GUARD (ZERO_GUARD)
   ) i_lu (
      .clk        (clk),
      .rst_n      (rst_n),
      .id_srcs    (id_srcs),
      .ex_rd      (ex_rd),
      .ex_we      (ex_reg_we),
      .ex_is_load (ex_is_load),
      .kill       (ex_br_taken),
      .stall      (stall)
   );

   hfc_redirect_arb i_arb (
      .stall      (stall),
      .br_taken   (ex_br_taken),
      .pc_we      (pc_we),
      .ifid_hold  (ifid_hold),
      .ifid_flush (ifid_flush),
      .ex_bubble  (ex_bubble)
   );
endmodule

// File: rtl/hzd_fwd_ctrl_chk.sv
module hzd_fwd_ctrl_chk #(
   parameter int unsigned REG_IDX_W = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [REG_IDX_W-1:0] ex_rs1,
   input logic [REG_IDX_W-1:0] mem_rd,
   input logic                 mem_reg_we,
   input logic                 ex_br_taken,
   input logic [1:0]           fwd_sel_a,
   input logic [1:0]           fwd_sel_b,
   input logic                 pc_we,
   input logic                 ifid_hold,
   input logic                 ifid_flush,
   input logic                 ex_bubble
);
   // R1 / R3: a newer matching producer always wins operand A
   p_newer_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_reg_we && mem_rd != '0 && mem_rd == ex_rs1) |-> fwd_sel_a == 2'b10);

   // R5: register 0 is never bypassed
   p_no_zero_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_rs1 == '0) |-> fwd_sel_a == 2'b00);

   // R2: only legal select codes
   p_sel_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11);

   // R6: a freeze lasts a single cycle
   p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_hold |=> !ifid_hold && !ex_bubble);

   // R6: PC and fetch/decode freeze together
   p_pc_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_hold |-> !pc_we && ex_bubble);

   // R8: flush follows a taken branch
   p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_flush == ex_br_taken);

   // R9: flush outranks freeze
   p_flush_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ex_br_taken |-> !ifid_hold && !ex_bubble && pc_we);
endmodule

bind hzd_fwd_ctrl hzd_fwd_ctrl_chk #(.REG_IDX_W(REG_IDX_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ex_rs1      (ex_rs1),
   .mem_rd      (mem_rd),
   .mem_reg_we  (mem_reg_we),
   .ex_br_taken (ex_br_taken),
   .fwd_sel_a   (fwd_sel_a),
   .fwd_sel_b   (fwd_sel_b),
   .pc_we       (pc_we),
   .ifid_hold   (ifid_hold),
   .ifid_flush  (ifid_flush),
   .ex_bubble   (ex_bubble)
);

// File: tb/test_hzd_fwd_ctrl.sv
module test_hzd_fwd_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
   logic ex_reg_we, ex_is_load, ex_br_taken, mem_reg_we, wb_reg_we;
   logic [1:0] fwd_sel_a, fwd_sel_b;
   logic pc_we, ifid_hold, ifid_flush, ex_bubble;
   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   hzd_fwd_ctrl i_hzd_fwd_ctrl (
      .clk(clk), .rst_n(rst_n),
      .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
      .ex_rd(ex_rd), .ex_reg_we(ex_reg_we), .ex_is_load(ex_is_load),
      .ex_br_taken(ex_br_taken), .mem_rd(mem_rd), .mem_reg_we(mem_reg_we),
      .wb_rd(wb_rd), .wb_reg_we(wb_reg_we),
      .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .pc_we(pc_we),
      .ifid_hold(ifid_hold), .ifid_flush(ifid_flush), .ex_bubble(ex_bubble)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle();
      id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
      mem_rd = 0; wb_rd = 0; ex_reg_we = 0; ex_is_load = 0;
      ex_br_taken = 0; mem_reg_we = 0; wb_reg_we = 0;
   endtask

   // drive on falling edge, sample 1 ns later
   task automatic settle();
      @(negedge clk);
   endtask

   task automatic check_freeze(string req, bit on);
      check({req, " hold"}, ifid_hold, on);
      check({req, " bubble"}, ex_bubble, on);
      check({req, " pc_we"}, pc_we, !on);
   endtask

   task automatic t_reset();
      idle(); #1;
      check("R10 sel_a", fwd_sel_a, 0);
      check("R10 sel_b", fwd_sel_b, 0);
      check("R10 flush", ifid_flush, 0);
      check_freeze("R10", 0);
   endtask

   task automatic t_bypass_basic();
      settle(); idle();
      ex_rs1 = 5; mem_rd = 5; mem_reg_we = 1; #1;
      check("R1 mem bypass", fwd_sel_a, 2);
      check("R2 no match b", fwd_sel_b, 0);
      settle(); idle();
      ex_rs2 = 9; wb_rd = 9; wb_reg_we = 1; #1;
      check("R2 wb bypass", fwd_sel_b, 1);
      check("R2 rf a", fwd_sel_a, 0);
   endtask

   task automatic t_priority();
      settle(); idle();
      ex_rs1 = 7; ex_rs2 = 7; mem_rd = 7; wb_rd = 7;
      mem_reg_we = 1; wb_reg_we = 1; #1;
      check("R3 newer a", fwd_sel_a, 2);
      check("R3 newer b", fwd_sel_b, 2);
   endtask

   task automatic t_dual();
      settle(); idle();
      ex_rs1 = 3; ex_rs2 = 4; mem_rd = 4; wb_rd = 3;
      mem_reg_we = 1; wb_reg_we = 1; #1;
      check("R4 a from wb", fwd_sel_a, 1);
      check("R4 b from mem", fwd_sel_b, 2);
   endtask

   task automatic t_guard();
      settle(); idle();
      mem_reg_we = 1; wb_reg_we = 1; #1;
      check("R5 x0 a", fwd_sel_a, 0);
      check("R5 x0 b", fwd_sel_b, 0);
      settle(); idle();
      ex_rs1 = 6; mem_rd = 6; wb_rd = 6; #1;
      check("R5 we low", fwd_sel_a, 0);
   endtask

   task automatic t_load_use();
      settle(); idle();
      ex_is_load = 1; ex_reg_we = 1; ex_rd = 8; id_rs2 = 8; #1;
      check_freeze("R6 first", 1);
      settle(); #1;
      check_freeze("R6 release", 0);
      settle(); idle();
      ex_is_load = 1; ex_reg_we = 1; ex_rd = 8; id_rs1 = 8; #1;
      check_freeze("R6 rs1 match", 1);
      settle(); idle(); #1;
   endtask

   task automatic t_no_stall();
      settle(); idle();
      ex_reg_we = 1; ex_rd = 8; id_rs1 = 8; #1;
      check_freeze("R7 not load", 0);
      settle(); idle();
      ex_is_load = 1; ex_reg_we = 1; ex_rd = 0; #1;
      check_freeze("R7 rd zero", 0);
      settle(); idle();
      ex_is_load = 1; ex_reg_we = 1; ex_rd = 8; id_rs1 = 2; id_rs2 = 3; #1;
      check_freeze("R7 no match", 0);
      settle(); idle();
      ex_is_load = 1; ex_rd = 8; id_rs1 = 8; #1;
      check_freeze("R7 we low", 0);
   endtask

   task automatic t_branch();
      settle(); idle();
      ex_br_taken = 1; #1;
      check("R8 flush", ifid_flush, 1);
      check_freeze("R8 taken", 0);
      settle(); idle(); #1;
      check("R8 not taken", ifid_flush, 0);
      check_freeze("R8 not taken", 0);
   endtask

   task automatic t_flush_prio();
      settle(); idle();
      ex_br_taken = 1; ex_is_load = 1; ex_reg_we = 1; ex_rd = 12; id_rs1 = 12; #1;
      check("R9 flush", ifid_flush, 1);
      check_freeze("R9 no freeze", 0);
      settle(); ex_br_taken = 0; #1;
      check_freeze("R9 freeze after", 1);
      settle(); idle(); #1;
   endtask

   initial begin
      fork
         begin
            idle();
            repeat (3) @(posedge clk);
            @(negedge clk); rst_n = 1'b1;
            t_reset();
            t_bypass_basic();
            t_priority();
            t_dual();
            t_guard();
            t_load_use();
            t_no_stall();
            t_branch();
            t_flush_prio();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule